// File: doc/BRIEF.md
# Word-Wide GPIO Control Register Bank

This block is the register side of a 32-bit general-purpose I/O controller. A simple single-cycle register bus (valid strobe, write-enable, address, write data, registered read data) reaches a pin-direction register, a read-only pin-level register and a free scratch register. The level register cannot be written directly. Software changes it through two write-only ports, one that sets bits and one that clears them. Each such write is accepted only when the written value overlaps at least one bit configured as an output.

Three addresses reserved for edge-detect configuration and status are decoded and swallow writes silently. Any access the bank cannot honour produces a one-cycle error pulse: a rejected set or clear, a write to an unknown or read-only address, or a read from an address without readable contents. A lower and an upper group of interrupt lines are present on the boundary but are held inactive. The bank is meant to sit behind a bus bridge that issues only full-word accesses with no back-pressure.

Top module: `gpio_regbank`

## Requirements
- R1: After reset the level, direction and scratch registers are all zero, read data is zero and the error pulse is low.
- R2: A write at 0x04 loads the direction register and a write at 0x20 loads the scratch register. A read at 0x00 (level), 0x04 (direction) or 0x20 (scratch) presents that register's value on read data in the cycle after the strobe. Read data holds its value until the next read.
- R3: A write at 0x08 whose value shares at least one set bit with the direction register ORs the whole written value, including bits configured as inputs, into the level register.
- R4: A write at 0x0C whose value shares at least one set bit with the direction register clears every written bit in the level register, including bits configured as inputs.
- R5: A write at 0x08 or 0x0C whose value shares no set bit with the direction register leaves the level register unchanged and raises the error pulse.
- R6: Writes at 0x10, 0x14 and 0x18 change no register and raise no error.
- R7: A write at 0x00, or at any address other than 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x20 (unaligned addresses included), changes no register and raises the error pulse.
- R8: A read at any address other than 0x00, 0x04 and 0x20 returns zero on read data and raises the error pulse.
- R9: The error pulse is high for exactly the one cycle after an offending access. It is low after any cycle in which the valid strobe is low or the access was legal.
- R10: All nine interrupt outputs (eight lower-group lines and one upper-group line) stay low at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |
| err_pulse | output | 1 | One-cycle error indication |
| irq_low | output | 8 | Lower-group interrupt lines, held low |
| irq_high | output | 1 | Upper-group interrupt line, held low |

## Verification
The gated set and clear ports are tried in three ways. Values overlap the outputs fully, which exercises the plain OR or AND-NOT. Values overlap only partly, so the input-configured bits in the same word show that the whole value is applied rather than a masked part. Values miss the outputs entirely, which separates a rejected write from an accepted one through the unchanged level and the error pulse. A random mix of every decoded, edge, read-only, unaligned and unknown address, with random data and random direction settings, tells the silent edge addresses apart from the erroring ones. Readback of each register after every kind of write exposes any stray update.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;

   // Address map; each offset is decoded exactly as listed
   localparam int unsigned OFS_LEVEL = 'h00;
   localparam int unsigned OFS_DIR   = 'h04;
   localparam int unsigned OFS_SET   = 'h08;
   localparam int unsigned OFS_CLR   = 'h0C;
   localparam int unsigned OFS_EDGR  = 'h10;
   localparam int unsigned OFS_EDGF  = 'h14;
   localparam int unsigned OFS_EDGS  = 'h18;
   localparam int unsigned OFS_AUX   = 'h20;

   // Smallest address width that still reaches the highest offset
   localparam int unsigned MIN_ADDR_W = 6;

   // Per-access strobes produced by the decoder
   typedef struct packed {
      logic wr_dir;
      logic wr_aux;
      logic wr_set;
      logic wr_clr;
      logic wr_quiet;
      logic wr_bad;
      logic rd_level;
      logic rd_dir;
      logic rd_aux;
      logic rd_bad;
   } gpio_strb_t;

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
   import gpio_regbank_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              valid_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   output gpio_strb_t        strb_o
);

   logic hit_level, hit_dir, hit_set, hit_clr, hit_aux, hit_edge;

   assign hit_level = (addr_i == ADDR_W'(OFS_LEVEL));
   assign hit_dir   = (addr_i == ADDR_W'(OFS_DIR));
   assign hit_set   = (addr_i == ADDR_W'(OFS_SET));
   assign hit_clr   = (addr_i == ADDR_W'(OFS_CLR));
   assign hit_aux   = (addr_i == ADDR_W'(OFS_AUX));
   assign hit_edge  = (addr_i == ADDR_W'(OFS_EDGR)) ||
                      (addr_i == ADDR_W'(OFS_EDGF)) ||
                      (addr_i == ADDR_W'(OFS_EDGS));

   always_comb begin
      strb_o = '0;
      if (valid_i) begin
         if (we_i) begin
            strb_o.wr_dir   = hit_dir;
            strb_o.wr_aux   = hit_aux;
            strb_o.wr_set   = hit_set;
            strb_o.wr_clr   = hit_clr;
            strb_o.wr_quiet = hit_edge;
            // level is read-only: a write there counts as undecoded
            strb_o.wr_bad   = !(hit_dir || hit_aux || hit_set ||
                                hit_clr || hit_edge);
         end else begin
            strb_o.rd_level = hit_level;
            strb_o.rd_dir   = hit_dir;
            strb_o.rd_aux   = hit_aux;
            strb_o.rd_bad   = !(hit_level || hit_dir || hit_aux);
         end
      end
   end

endmodule

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg #(
   parameter int unsigned            WIDTH   = 32,
   parameter logic [WIDTH-1:0]       RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [WIDTH-1:0] data_i,
   output logic [WIDTH-1:0] q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= RST_VAL;
      end else if (load_i) begin
         q_o <= data_i;
      end
   end

endmodule

// File: rtl/gpio_level_ctl.sv
module gpio_level_ctl #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_i,
   input  logic             clr_i,
   input  logic [WIDTH-1:0] wdata_i,
   input  logic [WIDTH-1:0] dir_i,
   output logic [WIDTH-1:0] level_o,
   output logic             reject_o
);

   logic overlap;
   logic [WIDTH-1:0] level_d;

   // gate: value must touch at least one output bit; whole value applies
   assign overlap  = |(dir_i & wdata_i);
   assign reject_o = (set_i || clr_i) && !overlap;

   always_comb begin
      level_d = level_o;
      if (overlap) begin
         if (set_i) begin
            level_d = level_o | wdata_i;
         end else if (clr_i) begin
            level_d = level_o & ~wdata_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_o <= '0;
      end else begin
         level_o <= level_d;
      end
   end

endmodule

// File: rtl/gpio_rd_port.sv
module gpio_rd_port
   import gpio_regbank_pkg::*;
#(
   parameter int unsigned WIDTH      = 32,
   parameter bit          RDATA_HOLD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  gpio_strb_t       strb_i,
   input  logic             reject_i,
   input  logic [WIDTH-1:0] level_i,
   input  logic [WIDTH-1:0] dir_i,
   input  logic [WIDTH-1:0] aux_i,
   output logic [WIDTH-1:0] rdata_o,
   output logic             err_o
);

   logic             rd_any;
   logic [WIDTH-1:0] rd_mux;

   assign rd_any = strb_i.rd_level || strb_i.rd_dir ||
                   strb_i.rd_aux   || strb_i.rd_bad;

   always_comb begin
      rd_mux = '0;
      if (strb_i.rd_level) rd_mux = level_i;
      if (strb_i.rd_dir)   rd_mux = dir_i;
      if (strb_i.rd_aux)   rd_mux = aux_i;
   end

   generate
      if (RDATA_HOLD) begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rdata_o <= '0;
            end else if (rd_any) begin
               rdata_o <= rd_mux;
            end
         end
      end else begin : g_zero
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rdata_o <= '0;
            end else begin
               rdata_o <= rd_mux;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_o <= 1'b0;
      end else begin
         err_o <= strb_i.wr_bad || strb_i.rd_bad || reject_i;
      end
   end

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
   import gpio_regbank_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned N_IRQ_LOW  = 8,
   parameter bit          RDATA_HOLD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              err_pulse,
   output logic [N_IRQ_LOW-1:0] irq_low,
   output logic              irq_high
);

   if (ADDR_W < MIN_ADDR_W) begin : g_chk_addr
      $error("gpio_regbank: ADDR_W too small for the address map");
   end
   if (DATA_W != 32) begin : g_chk_data
      $error("gpio_regbank: only full 32-bit words are supported");
   end
   if (N_IRQ_LOW == 0) begin : g_chk_irq
      $error("gpio_regbank: N_IRQ_LOW must be at least 1");
   end

   gpio_strb_t        strb;
   logic [DATA_W-1:0] lvl_val;
   logic [DATA_W-1:0] dir_val;
   logic [DATA_W-1:0] aux_val;
   logic              gate_reject;

   gpio_bus_decode #(.ADDR_W(ADDR_W)) i_dec (
      .valid_i (bus_valid),
      .we_i    (bus_we),
      .addr_i  (bus_addr),
      .strb_o  (strb)
   );

   gpio_cfg_reg #(.WIDTH(DATA_W), .RST_VAL('0)) i_dir (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (strb.wr_dir),
      .data_i (bus_wdata),
      .q_o    (dir_val)
   );

   gpio_cfg_reg #(.WIDTH(DATA_W), .RST_VAL('0)) i_aux (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (strb.wr_aux),
      .data_i (bus_wdata),
      .q_o    (aux_val)
   );

   gpio_level_ctl #(.WIDTH(DATA_W)) i_lvl (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (strb.wr_set),
      .clr_i    (strb.wr_clr),
      .wdata_i  (bus_wdata),
      .dir_i    (dir_val),
      .level_o  (lvl_val),
      .reject_o (gate_reject)
   );

   gpio_rd_port #(.WIDTH(DATA_W), .RDATA_HOLD(RDATA_HOLD)) i_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .strb_i   (strb),
      .reject_i (gate_reject),
      .level_i  (lvl_val),
      .dir_i    (dir_val),
      .aux_i    (aux_val),
      .rdata_o  (bus_rdata),
      .err_o    (err_pulse)
   );

   // interrupt lines exist on the boundary but are never raised
   for (genvar gi = 0; gi < N_IRQ_LOW; gi++) begin : g_irq_low
      assign irq_low[gi] = 1'b0;
   end
   assign irq_high = 1'b0;

endmodule

// File: rtl/gpio_regbank_chk.sv
module gpio_regbank_chk
   import gpio_regbank_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned N_IRQ_LOW = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              err_pulse,
   input logic [N_IRQ_LOW-1:0] irq_low,
   input logic              irq_high,
   input logic [DATA_W-1:0] lvl_val,
   input logic [DATA_W-1:0] dir_val
);

   logic wr_set, wr_clr, wr_edge, rd_ok, ovl;
   assign wr_set  = bus_valid && bus_we && (bus_addr == ADDR_W'(OFS_SET));
   assign wr_clr  = bus_valid && bus_we && (bus_addr == ADDR_W'(OFS_CLR));
   assign wr_edge = bus_valid && bus_we &&
                    ((bus_addr == ADDR_W'(OFS_EDGR)) ||
                     (bus_addr == ADDR_W'(OFS_EDGF)) ||
                     (bus_addr == ADDR_W'(OFS_EDGS)));
   assign rd_ok   = (bus_addr == ADDR_W'(OFS_LEVEL)) ||
                    (bus_addr == ADDR_W'(OFS_DIR)) ||
                    (bus_addr == ADDR_W'(OFS_AUX));
   assign ovl     = |(dir_val & bus_wdata);

   p_set_whole_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_set && ovl) |=> (lvl_val == ($past(lvl_val) | $past(bus_wdata))));

   p_clr_whole_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && ovl) |=> (lvl_val == ($past(lvl_val) & ~$past(bus_wdata))));

   p_gate_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_set || wr_clr) && !ovl) |=> (err_pulse && $stable(lvl_val)));

   p_edge_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_edge |=> (!err_pulse && $stable(lvl_val) && $stable(dir_val)));

   p_bad_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_we && !rd_ok) |=> (err_pulse && bus_rdata == '0));

   p_idle_no_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |=> !err_pulse);

   p_irq_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_low == '0) && !irq_high);

endmodule

bind gpio_regbank gpio_regbank_chk #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .N_IRQ_LOW (N_IRQ_LOW)
) i_gpio_regbank_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_valid (bus_valid),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .err_pulse (err_pulse),
   .irq_low   (irq_low),
   .irq_high  (irq_high),
   .lvl_val   (lvl_val),
   .dir_val   (dir_val)
);

// File: tb/test_gpio_regbank.sv
module test_gpio_regbank;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_valid = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          err_pulse;
   logic [7:0]    irq_low;
   logic          irq_high;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // bench model of the register contents
   logic [DW-1:0] m_lvl = '0, m_dir = '0, m_aux = '0, m_rd = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_regbank i_gpio_regbank (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .err_pulse(err_pulse), .irq_low(irq_low), .irq_high(irq_high)
   );

   task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // expected error and model update for one access
   function automatic bit model_access(bit we, logic [AW-1:0] a, logic [DW-1:0] d);
      bit e = 1'b0;
      if (we) begin
         case (a)
            8'h04: m_dir = d;
            8'h20: m_aux = d;
            8'h08: if ((m_dir & d) != 0) m_lvl = m_lvl | d; else e = 1'b1;
            8'h0C: if ((m_dir & d) != 0) m_lvl = m_lvl & ~d; else e = 1'b1;
            8'h10, 8'h14, 8'h18: e = 1'b0;
            default: e = 1'b1;
         endcase
      end else begin
         case (a)
            8'h00: m_rd = m_lvl;
            8'h04: m_rd = m_dir;
            8'h20: m_rd = m_aux;
            default: begin m_rd = '0; e = 1'b1; end
         endcase
      end
      return e;
   endfunction

   task automatic access(bit we, logic [AW-1:0] a, logic [DW-1:0] d, string req);
      bit e;
      @(negedge clk);
      bus_valid = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
      e = model_access(we, a, d);
      @(negedge clk);
      bus_valid = 1'b0;
      check({req, " err"}, {31'd0, err_pulse}, {31'd0, e});
      if (!we) check({req, " rdata"}, bus_rdata, m_rd);
      check("R10 irq", {23'd0, irq_high, irq_low}, '0);
   endtask

   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, string req);
      access(1'b1, a, d, req);
   endtask

   task automatic rd(logic [AW-1:0] a, string req);
      access(1'b0, a, '0, req);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin : stim
      logic [AW-1:0] addrs [12];
      void'($urandom(32'h5eed_0042));
      addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h20,
                8'h1C, 8'h24, 8'h02, 8'h09};
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check("R1 rdata", bus_rdata, '0);
      check("R1 err", {31'd0, err_pulse}, '0);
      rst_n = 1'b1;
      rd(8'h00, "R1 level");
      rd(8'h04, "R1 dir");
      rd(8'h20, "R1 aux");

      // R2: direction and scratch readback, hold between reads
      wr(8'h04, 32'h0000_00F0, "R2");
      wr(8'h20, 32'hCAFE_F00D, "R2");
      rd(8'h20, "R2 aux");
      wr(8'h10, 32'h1, "R2 hold");
      check("R2 hold rdata", bus_rdata, 32'hCAFE_F00D);
      rd(8'h04, "R2 dir");

      // R3: partial overlap sets the input bits as well
      wr(8'h08, 32'h0000_0F10, "R3");
      rd(8'h00, "R3 level");
      // R4: partial overlap clears input bits too
      wr(8'h0C, 32'h0000_0310, "R4");
      rd(8'h00, "R4 level");
      // R5: no overlap on set and on clear
      wr(8'h08, 32'h0001_0000, "R5 set");
      wr(8'h0C, 32'h0000_0C00, "R5 clr");
      rd(8'h00, "R5 level");
      // R6: edge addresses silent
      wr(8'h10, 32'hFFFF_FFFF, "R6");
      wr(8'h14, 32'hFFFF_FFFF, "R6");
      wr(8'h18, 32'hFFFF_FFFF, "R6");
      rd(8'h04, "R6 dir");
      rd(8'h00, "R6 level");
      // R7: read-only level, unknown and unaligned writes
      wr(8'h00, 32'hFFFF_FFFF, "R7");
      wr(8'h1C, 32'hFFFF_FFFF, "R7");
      wr(8'h05, 32'hFFFF_FFFF, "R7");
      rd(8'h00, "R7 level");
      rd(8'h04, "R7 dir");
      rd(8'h20, "R7 aux");
      // R8: bad reads give zero
      rd(8'h08, "R8");
      rd(8'h10, "R8");
      rd(8'h21, "R8");
      // R9: error lasts one cycle, idle gives none
      wr(8'h3C, 32'h0, "R9");
      @(negedge clk);
      check("R9 idle err", {31'd0, err_pulse}, '0);

      // random mix
      for (int i = 0; i < 600; i++) begin
         logic [AW-1:0] a;
         logic [DW-1:0] d;
         a = addrs[$urandom_range(11)];
         case ($urandom_range(3))
            0: d = 32'h1 << $urandom_range(31);
            1: d = $urandom & 32'h0000_FFFF;
            default: d = $urandom;
         endcase
         access($urandom_range(1) == 1, a, d, "R3 R4 R5 R6 R7 R8 random");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule